// File: doc/BRIEF.md
# Twin-Predicated Element Mover

This block copies elements from a source vector array into a destination vector array under control of two independent predicate masks. The source mask chooses, lowest element first, which source elements are consumed; the destination mask chooses, lowest slot first, which destination slots receive them. The k-th enabled source element always lands in the k-th enabled destination slot. A single datapath therefore covers plain copy, compress, expand, compress-then-expand, splat (scalar source), extract (scalar destination with a one-hot source mask) and insert (scalar source with a one-hot destination mask).

Each array has `VLMAX` elements of `W` bits and lives inside the block. A load port fills either array while the block is idle. A combinational read port returns any element of either array. An operation starts with a one-cycle `start` pulse that carries the vector length, both masks and the two scalar flags. The block walks a source index and a destination index, moves at most one element per cycle, and raises `done` for one cycle at the end. The only per-element operation is a plain move.

Top module: `twin_move`

## Requirements
- R1: Bit i of `src_mask` enables source element i, and bit i of `dst_mask` enables destination slot i. Each index starts at 0 and steps upward past disabled positions. When both indices rest on enabled positions, the source element is copied into the destination slot and both indices advance. The k-th enabled source element therefore reaches the k-th enabled destination slot.
- R2: An operation ends as soon as either index reaches the vector length. Destination slots that were not written keep their previous contents.
- R3: When `src_scalar` is 1, the source index stays at 0 and `src_mask` is ignored. Source element 0 is written to every enabled destination slot below the vector length.
- R4: When `dst_scalar` is 1, the destination index stays at 0 and `dst_mask` is ignored. The operation ends after the first transfer, so exactly one write to slot 0 can occur, and it carries the first enabled source element.
- R5: A start with vector length 0 writes nothing. `done` is high in the cycle after the start edge, and `busy` stays low.
- R6: `done` lasts one cycle, and `busy` is low while `done` is high. For a nonzero vector length, `busy` is high in the cycle after the start edge.
- R7: A `start` pulse that arrives while `busy` is high is ignored. The running operation completes with its own parameters.
- R8: A load (`ld_en`) issued while `busy` is high is ignored. An operation never changes the source array.
- R9: A vector length larger than `VLMAX` behaves exactly as `VLMAX`.
- R10: `rd_data` returns the destination element `rd_idx` when `rd_dst` is 1, and the source element `rd_idx` when `rd_dst` is 0. It is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts an operation while idle |
| vl | input | VLW | Vector length (clamped to VLMAX) |
| src_mask | input | VLMAX | Source predicate, bit i enables element i |
| dst_mask | input | VLMAX | Destination predicate, bit i enables slot i |
| src_scalar | input | 1 | Source is scalar element 0 |
| dst_scalar | input | 1 | Destination is scalar slot 0 |
| ld_en | input | 1 | Load one array element (idle only) |
| ld_dst | input | 1 | Load target: 1 destination, 0 source |
| ld_idx | input | IDXW | Load element index |
| ld_data | input | W | Load data |
| rd_dst | input | 1 | Read select: 1 destination, 0 source |
| rd_idx | input | IDXW | Read element index |
| rd_data | output | W | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The assertions check, on every cycle, properties that need no reference result:
- the shape of the `done` pulse and its exclusion with `busy`;
- the immediate finish at length zero;
- that element writes happen only inside an operation;
- that a scalar destination receives at most one write;
- that the source array stays frozen while busy.

Which element lands in which slot depends on the pairing of enabled positions, and only the bench's scenarios can show it. The bench compares whole arrays against a model for copy, compress, expand, their combination, splat, insert, extract, short lengths, exhausted masks and clamping. It also shows that a second start or a load issued mid-operation has no effect.

// File: rtl/twin_move_pkg.sv
package twin_move_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/twin_move_regs.sv
module twin_move_regs #(
  parameter int W     = 16,
  parameter int VLMAX = 8,
  localparam int IDXW = (VLMAX > 1) ? $clog2(VLMAX) : 1
) (
  input  logic               clk,
  input  logic               ld_en,
  input  logic               ld_dst,
  input  logic [IDXW-1:0]    ld_idx,
  input  logic [W-1:0]       ld_data,
  input  logic               eng_we,
  input  logic [IDXW-1:0]    eng_widx,
  input  logic [IDXW-1:0]    eng_ridx,
  output logic [W-1:0]       eng_rdata,
  input  logic               rd_dst,
  input  logic [IDXW-1:0]    rd_idx,
  output logic [W-1:0]       rd_data,
  output logic [VLMAX*W-1:0] src_flat
);
  logic [W-1:0] src_mem [VLMAX];
  logic [W-1:0] dst_mem [VLMAX];

  for (genvar g = 0; g < VLMAX; g++) begin : g_row
    logic src_en, dst_eng_en, dst_ld_en;
    assign src_en     = ld_en && !ld_dst && (ld_idx == IDXW'(g));
    assign dst_eng_en = eng_we && (eng_widx == IDXW'(g));
    assign dst_ld_en  = ld_en && ld_dst && (ld_idx == IDXW'(g));

    always_ff @(posedge clk) begin
      if (src_en) src_mem[g] <= ld_data;
    end

    always_ff @(posedge clk) begin
      if (dst_eng_en)     dst_mem[g] <= eng_rdata;
      else if (dst_ld_en) dst_mem[g] <= ld_data;
    end

    assign src_flat[g*W +: W] = src_mem[g];
  end

  assign eng_rdata = src_mem[eng_ridx];
  assign rd_data   = rd_dst ? dst_mem[rd_idx] : src_mem[rd_idx];
endmodule

// File: rtl/twin_move_walk.sv
module twin_move_walk
  import twin_move_pkg::*;
#(
  parameter int VLMAX = 8,
  localparam int IDXW = (VLMAX > 1) ? $clog2(VLMAX) : 1,
  localparam int VLW  = $clog2(VLMAX + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VLW-1:0]   vl,
  input  logic [VLMAX-1:0] src_mask,
  input  logic [VLMAX-1:0] dst_mask,
  input  logic             src_scalar,
  input  logic             dst_scalar,
  output logic             busy,
  output logic             done,
  output logic             we,
  output logic [IDXW-1:0]  widx,
  output logic [IDXW-1:0]  ridx,
  output logic             dst_scalar_q
);
  walk_state_e      state_q, state_d;
  logic [VLW-1:0]   si_q, si_d, di_q, di_d, vl_q, vl_eff;
  logic [VLMAX-1:0] sm_q, dm_q;
  logic             ss_q, ds_q, done_q, done_d;
  logic             accept, fin, sok, dok, move, idx_en;

  assign vl_eff = (vl > VLW'(VLMAX)) ? VLW'(VLMAX) : vl;
  assign accept = (state_q == ST_IDLE) && start;
  assign fin    = (si_q >= vl_q) || (di_q >= vl_q);
  assign sok    = ss_q || sm_q[si_q[IDXW-1:0]];
  assign dok    = ds_q || dm_q[di_q[IDXW-1:0]];
  assign move   = (state_q == ST_RUN) && !fin && sok && dok;

  always_comb begin
    state_d = state_q;
    si_d    = si_q;
    di_d    = di_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          si_d = '0;
          di_d = '0;
          if (vl_eff == '0) done_d  = 1'b1;
          else              state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (fin) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (move) begin
          if (ds_q) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            di_d = di_q + 1'b1;
            if (!ss_q) si_d = si_q + 1'b1;
          end
        end else begin
          if (!sok) si_d = si_q + 1'b1;
          if (!dok) di_d = di_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign idx_en = accept || (state_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      si_q    <= '0;
      di_q    <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (idx_en) begin
        si_q <= si_d;
        di_q <= di_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q <= '0;
      sm_q <= '0;
      dm_q <= '0;
      ss_q <= 1'b0;
      ds_q <= 1'b0;
    end else if (accept) begin
      vl_q <= vl_eff;
      sm_q <= src_mask;
      dm_q <= dst_mask;
      ss_q <= src_scalar;
      ds_q <= dst_scalar;
    end
  end

  assign busy         = (state_q == ST_RUN);
  assign done         = done_q;
  assign we           = move;
  assign widx         = di_q[IDXW-1:0];
  assign ridx         = si_q[IDXW-1:0];
  assign dst_scalar_q = ds_q;
endmodule

// File: rtl/twin_move.sv
module twin_move #(
  parameter int W     = 16,
  parameter int VLMAX = 8,
  localparam int IDXW = (VLMAX > 1) ? $clog2(VLMAX) : 1,
  localparam int VLW  = $clog2(VLMAX + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VLW-1:0]   vl,
  input  logic [VLMAX-1:0] src_mask,
  input  logic [VLMAX-1:0] dst_mask,
  input  logic             src_scalar,
  input  logic             dst_scalar,
  input  logic             ld_en,
  input  logic             ld_dst,
  input  logic [IDXW-1:0]  ld_idx,
  input  logic [W-1:0]     ld_data,
  input  logic             rd_dst,
  input  logic [IDXW-1:0]  rd_idx,
  output logic [W-1:0]     rd_data,
  output logic             busy,
  output logic             done
);
  logic               eng_we, ds_lat, ld_gated;
  logic [IDXW-1:0]    eng_widx, eng_ridx;
  logic [W-1:0]       eng_rdata;
  logic [VLMAX*W-1:0] src_flat;

  assign ld_gated = ld_en && !busy;

  twin_move_walk #(.VLMAX(VLMAX)) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .vl           (vl),
    .src_mask     (src_mask),
    .dst_mask     (dst_mask),
    .src_scalar   (src_scalar),
    .dst_scalar   (dst_scalar),
    .busy         (busy),
    .done         (done),
    .we           (eng_we),
    .widx         (eng_widx),
    .ridx         (eng_ridx),
    .dst_scalar_q (ds_lat)
  );

  twin_move_regs #(.W(W), .VLMAX(VLMAX)) u_regs (
    .clk       (clk),
    .ld_en     (ld_gated),
    .ld_dst    (ld_dst),
    .ld_idx    (ld_idx),
    .ld_data   (ld_data),
    .eng_we    (eng_we),
    .eng_widx  (eng_widx),
    .eng_ridx  (eng_ridx),
    .eng_rdata (eng_rdata),
    .rd_dst    (rd_dst),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .src_flat  (src_flat)
  );
endmodule

// File: rtl/twin_move_chk.sv
module twin_move_chk #(
  parameter int W     = 16,
  parameter int VLMAX = 8,
  localparam int VLW  = $clog2(VLMAX + 1) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [VLW-1:0]     vl,
  input logic               busy,
  input logic               done,
  input logic               eng_we,
  input logic               ds_lat,
  input logic [VLMAX*W-1:0] src_flat
);
  logic [1:0] wcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wcnt_q <= '0;
    else if (start && !busy)    wcnt_q <= '0;
    else if (eng_we && wcnt_q != 2'd3) wcnt_q <= wcnt_q + 1'b1;
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R5
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vl == '0) |=> (done && !busy));
  // R2
  write_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> busy);
  // R4
  scalar_dst_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && wcnt_q != 2'd0) |-> !ds_lat);
  // R8
  src_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(src_flat));
endmodule

bind twin_move twin_move_chk #(.W(W), .VLMAX(VLMAX)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .vl       (vl),
  .busy     (busy),
  .done     (done),
  .eng_we   (eng_we),
  .ds_lat   (ds_lat),
  .src_flat (src_flat)
);

// File: tb/twin_move_bench.sv
module twin_move_bench;
  localparam int W = 16;
  localparam int N = 8;
  localparam int IDXW = 3;
  localparam int VLW = 5;

  typedef struct packed {
    logic [VLW-1:0] vl;
    logic [N-1:0]   sm;
    logic [N-1:0]   dm;
    logic           ss;
    logic           ds;
  } case_t;

  localparam int NC = 12;
  localparam case_t CASES [NC] = '{
    '{5'd8, 8'hFF, 8'hFF, 1'b0, 1'b0},  // R1 plain copy
    '{5'd8, 8'hA5, 8'hFF, 1'b0, 1'b0},  // R1 compress
    '{5'd8, 8'hFF, 8'h5A, 1'b0, 1'b0},  // R1 expand
    '{5'd8, 8'hC3, 8'h3C, 1'b0, 1'b0},  // R1 compress then expand
    '{5'd8, 8'h00, 8'hB6, 1'b1, 1'b0},  // R3 splat
    '{5'd8, 8'h08, 8'hFF, 1'b0, 1'b1},  // R4 extract
    '{5'd8, 8'hFF, 8'h20, 1'b1, 1'b0},  // R3 insert
    '{5'd5, 8'hFF, 8'hFF, 1'b0, 1'b0},  // R2 short length
    '{5'd8, 8'hFF, 8'h01, 1'b0, 1'b0},  // R2 destination mask exhausted
    '{5'd8, 8'h00, 8'hFF, 1'b0, 1'b0},  // R2 empty source mask
    '{5'd8, 8'h00, 8'h00, 1'b1, 1'b1},  // R4 scalar to scalar
    '{5'd3, 8'h10, 8'hFF, 1'b0, 1'b1}   // R2 extract beyond length
  };

  logic clk, rst_n, start, src_scalar, dst_scalar, ld_en, ld_dst, rd_dst, busy, done;
  logic [VLW-1:0] vl;
  logic [N-1:0] src_mask, dst_mask;
  logic [IDXW-1:0] ld_idx, rd_idx;
  logic [W-1:0] ld_data, rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [W-1:0] s_img [N];
  logic [W-1:0] d_img [N];

  twin_move #(.W(W), .VLMAX(N)) u_twin_move (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .src_mask(src_mask), .dst_mask(dst_mask),
    .src_scalar(src_scalar), .dst_scalar(dst_scalar),
    .ld_en(ld_en), .ld_dst(ld_dst), .ld_idx(ld_idx), .ld_data(ld_data),
    .rd_dst(rd_dst), .rd_idx(rd_idx), .rd_data(rd_data),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual run still going, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic dst, input int idx, input logic [W-1:0] data);
    @(negedge clk);
    ld_en = 1'b1; ld_dst = dst; ld_idx = IDXW'(idx); ld_data = data;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < N; i++) begin
      s_img[i] = W'(16'h1000 + seed * 16'h0100 + i);
      d_img[i] = W'(16'hD000 + seed * 16'h0010 + i);
      load(1'b0, i, s_img[i]);
      load(1'b1, i, d_img[i]);
    end
  endtask

  // Reference: apply requirements R1-style walking to d_img
  task automatic model(input case_t c);
    int si, di, len;
    logic sok, dok;
    si = 0; di = 0;
    len = (int'(c.vl) > N) ? N : int'(c.vl);
    while (si < len && di < len) begin
      sok = c.ss || c.sm[si];
      dok = c.ds || c.dm[di];
      if (sok && dok) begin
        d_img[di] = s_img[si];
        if (c.ds) break;
        di++;
        if (!c.ss) si++;
      end else begin
        if (!sok) si++;
        if (!dok) di++;
      end
    end
  endtask

  task automatic launch(input case_t c);
    @(negedge clk);
    start = 1'b1; vl = c.vl; src_mask = c.sm; dst_mask = c.dm;
    src_scalar = c.ss; dst_scalar = c.ds;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(req, W'(done), W'(1));
  endtask

  task automatic compare(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < N; i++) begin
      rd_dst = 1'b1; rd_idx = IDXW'(i); #1;
      if (rd_data !== d_img[i]) begin
        bad++;
        errors++;
        $display("FAIL %s: dst[%0d] actual %h expected %h", req, i, rd_data, d_img[i]);
      end
      rd_dst = 1'b0; #1;
      if (rd_data !== s_img[i]) begin
        bad++;
        errors++;
        $display("FAIL %s: src[%0d] actual %h expected %h", req, i, rd_data, s_img[i]);
      end
    end
    checks++;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; vl = '0; src_mask = '0; dst_mask = '0;
    src_scalar = 1'b0; dst_scalar = 1'b0; ld_en = 1'b0; ld_dst = 1'b0;
    ld_idx = '0; ld_data = '0; rd_dst = 1'b0; rd_idx = '0;
    repeat (3) @(negedge clk);
    chk("R6 reset busy", W'(busy), W'(0));
    chk("R6 reset done", W'(done), W'(0));
    rst_n = 1'b1;

    // Table-driven scenarios: R1 R2 R3 R4 R10
    for (int k = 0; k < NC; k++) begin
      fill(k);
      launch(CASES[k]);
      if (CASES[k].vl != '0) chk("R6 busy after start", W'(busy), W'(1));
      wait_done("R6 done reached");
      @(negedge clk);
      chk("R6 done one cycle", W'(done), W'(0));
      model(CASES[k]);
      compare($sformatf("R1 case %0d", k));
    end

    // R5: zero length
    fill(20);
    launch('{5'd0, 8'hFF, 8'hFF, 1'b0, 1'b0});
    chk("R5 done next cycle", W'(done), W'(1));
    chk("R5 busy low", W'(busy), W'(0));
    compare("R5 no writes");

    // R9: length above VLMAX clamps
    fill(21);
    launch('{5'd12, 8'hFF, 8'h81, 1'b0, 1'b0});
    wait_done("R9 done");
    model('{5'd8, 8'hFF, 8'h81, 1'b0, 1'b0});
    compare("R9 clamp");

    // R7 and R8: second start and a load mid-operation are ignored
    fill(22);
    launch('{5'd8, 8'h80, 8'hFF, 1'b0, 1'b0});
    @(negedge clk);
    start = 1'b1; vl = 5'd8; src_mask = 8'hFF; dst_mask = 8'hFF;
    src_scalar = 1'b1; dst_scalar = 1'b0;
    ld_en = 1'b1; ld_dst = 1'b0; ld_idx = 3'd7; ld_data = 16'hBEEF;
    @(negedge clk);
    start = 1'b0; ld_en = 1'b0;
    wait_done("R7 done");
    @(negedge clk);
    model('{5'd8, 8'h80, 8'hFF, 1'b0, 1'b0});
    compare("R7 R8 ignored during busy");
    chk("R7 idle after op", W'(busy), W'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule